// File: doc/BRIEF.md
# Halt Wake-Up and Reset-Cause Controller

This block manages a core's power-down state. A halt strobe from the core stops the core clock and leaves the controller waiting for a wake event. A wake event can be an external reset, a watchdog overflow, a newly raised interrupt request, or a falling edge on an enabled port pin. Once one occurs, the controller restarts the core clock but keeps execution held for a fixed settling period. At the end of that period it emits a single one-cycle strobe that tells the core how to continue:

- resume at the next instruction,
- enter the interrupt response,
- perform a warm restart (program counter and stack pointer only), or
- perform a full chip restart.

The controller also keeps two reset-cause flags that software reads after a restart: a time-out flag and a power-down flag. The pair tells apart power-up, an external reset while running, an external reset out of halt, a watchdog time-out while running, and a watchdog wake from halt. Port A has one wake enable per pin. Ports B, C and D each have a single enable that covers the whole port. An interrupt whose request is already pending when halt is entered is disarmed for that halt. The interrupt tied to the external pin never wakes the device.

Top module: `pwk_halt_ctrl`

## Requirements
- R1: After power-up reset, `to_flag`=0, `pdf_flag`=0, `sys_clk_en`=1, `cpu_hold`=0 and all four exit strobes are 0.
- R2: A `halt_req` while running, with no `ext_rst_req` or `wdt_ovf` in the same cycle, takes effect on the next cycle. From then `sys_clk_en`=0 and `cpu_hold`=1, `pdf_flag` is set and `to_flag` is cleared.
- R3: While halted, a high-to-low transition on port A bit i wakes the device only if `pa_wake_en[i]`=1. Low-to-high transitions never wake.
- R4: While halted, a falling edge on any pin of port B, C or D wakes the device only if that port's single enable is 1.
- R5: An interrupt wakes the device when its request bit rises during halt. A bit already set at halt entry cannot wake. Interrupt index `EXT_IRQ_IDX` (default 0) never wakes.
- R6: After a wake event, `sys_clk_en`=1 and `cpu_hold`=1 for exactly `SETTLE_CYC` (default 1024) cycles. On the next cycle `cpu_hold`=0 and exactly one exit strobe is high for one cycle.
- R7: A port wake ends with `resume_next`. So does an interrupt wake in which no waking interrupt is enabled, or in which `stack_full`=1.
- R8: An interrupt wake in which some waking interrupt is enabled and `stack_full`=0 ends with `take_irq`. `take_irq_id` then gives the lowest enabled waking index.
- R9: An external reset during halt makes the flags `to`/`pdf` = 0/1 and ends with `chip_rst`.
- R10: A watchdog overflow during halt makes the flags 1/1 and ends with `warm_rst`.
- R11: A watchdog overflow while running sets `to_flag`, leaves `pdf_flag` unchanged and pulses `chip_rst` on the next cycle. An external reset while running leaves both flags unchanged and raises no strobe.
- R12: `wdt_clr` while running clears `pdf_flag`.
- R13: When wake sources coincide, priority is external reset, then watchdog, then interrupt, then port.
- R14: During the settling period, `halt_req`, `ext_rst_req` and `wdt_ovf` have no effect on the flags, the period length or the exit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timing clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| halt_req | input | 1 | Halt command strobe from the core |
| ext_rst_req | input | 1 | External reset event pulse |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| wdt_clr | input | 1 | Watchdog clear command pulse |
| pa_in | input | PA_W | Port A pin levels |
| pa_wake_en | input | PA_W | Port A per-pin wake enables |
| pb_in | input | GRP_W | Port B pin levels |
| pc_in | input | GRP_W | Port C pin levels |
| pd_in | input | GRP_W | Port D pin levels |
| pb_wake_en | input | 1 | Port B wake enable |
| pc_wake_en | input | 1 | Port C wake enable |
| pd_wake_en | input | 1 | Port D wake enable |
| irq_req | input | N_IRQ | Interrupt request flags |
| irq_en | input | N_IRQ | Interrupt enables |
| stack_full | input | 1 | Return stack full |
| sys_clk_en | output | 1 | Core clock enable, low while halted |
| cpu_hold | output | 1 | Execution held (halt or settling) |
| resume_next | output | 1 | Continue at the next instruction |
| take_irq | output | 1 | Enter the interrupt response |
| take_irq_id | output | IRQ_IDW | Interrupt index for `take_irq` |
| warm_rst | output | 1 | Reset program counter and stack pointer only |
| chip_rst | output | 1 | Full chip restart |
| to_flag | output | 1 | Time-out flag |
| pdf_flag | output | 1 | Power-down flag |

## Verification
The bench targets the following corners; each is paired with the failure it would expose.

- An interrupt that is already pending at halt entry, and the external-pin interrupt. A design that forgets to disarm either would wake at once and never sleep.
- Rising port edges and disabled enables. A wrong edge polarity or a mixed-up group enable would leave halt on noise, or stay asleep forever.
- Coincident wake sources and the choice of the lowest enabled interrupt. These show up as the wrong strobe or the wrong index.
- A settling period disturbed by fresh halt, watchdog and reset pulses. A design off by one would show a period of 1023 or 1025 cycles; a design that re-samples its inputs during settling would corrupt the flags or the exit.

// File: rtl/pwk_pkg.sv
package pwk_pkg;

   typedef enum logic [1:0] {
      PWK_RUN    = 2'd0,
      PWK_HALT   = 2'd1,
      PWK_SETTLE = 2'd2
   } pwk_state_e;

   typedef enum logic [1:0] {
      PWK_EXIT_NEXT = 2'd0,
      PWK_EXIT_VEC  = 2'd1,
      PWK_EXIT_WARM = 2'd2,
      PWK_EXIT_COLD = 2'd3
   } pwk_exit_e;

endpackage

// File: rtl/pwk_edge_det.sv
// Falling-edge wake detector for one group of port pins.
module pwk_edge_det #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pins,
   input  logic [W-1:0] en,
   output logic         hit
);

   logic [W-1:0] prev_q;

   // Cleared at reset so a pin held low out of reset is not seen as an edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pins;
   end

   assign hit = |(prev_q & ~pins & en);

endmodule

// File: rtl/pwk_irq_gate.sv
// Arms interrupts at halt entry and picks the vectored candidate.
module pwk_irq_gate #(
   parameter int N       = 4,
   parameter int HAS_EXT = 1,
   parameter int EXT_IDX = 0,
   parameter int IDW     = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           arm,
   input  logic [N-1:0]   req,
   input  logic [N-1:0]   en,
   output logic           wake,
   output logic           vec_ok,
   output logic [IDW-1:0] vec_id
);

   logic [N-1:0] ext_mask;
   logic [N-1:0] armed_q;
   logic [N-1:0] waking;
   logic [N-1:0] cand;

   generate
      if (HAS_EXT != 0) begin : g_ext
         assign ext_mask = N'(1) << EXT_IDX;
      end else begin : g_noext
         assign ext_mask = '0;
      end
   endgenerate

   // Anything already requesting at entry is excluded for this halt.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   armed_q <= '0;
      else if (arm) armed_q <= ~req & ~ext_mask;
   end

   assign waking = req & armed_q;
   assign wake   = |waking;
   assign cand   = waking & en;
   assign vec_ok = |cand;

   // Lowest index wins.
   always_comb begin
      vec_id = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (cand[i]) vec_id = IDW'(i);
      end
   end

endmodule

// File: rtl/pwk_settle_timer.sv
// Counts the settling window; last is high in its final cycle.
module pwk_settle_timer #(
   parameter int N  = 1024,
   parameter int CW = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic last
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (!run) cnt_q <= '0;
      else           cnt_q <= cnt_q + CW'(1);
   end

   assign last = run && (cnt_q == CW'(N - 1));

endmodule

// File: rtl/pwk_halt_ctrl.sv
module pwk_halt_ctrl
   import pwk_pkg::*;
#(
   parameter int PA_W        = 8,
   parameter int GRP_W       = 8,
   parameter int N_IRQ       = 4,
   parameter int HAS_EXT_IRQ = 1,
   parameter int EXT_IRQ_IDX = 0,
   parameter int SETTLE_CYC  = 1024,
   localparam int IRQ_IDW    = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               halt_req,
   input  logic               ext_rst_req,
   input  logic               wdt_ovf,
   input  logic               wdt_clr,
   input  logic [PA_W-1:0]    pa_in,
   input  logic [PA_W-1:0]    pa_wake_en,
   input  logic [GRP_W-1:0]   pb_in,
   input  logic [GRP_W-1:0]   pc_in,
   input  logic [GRP_W-1:0]   pd_in,
   input  logic               pb_wake_en,
   input  logic               pc_wake_en,
   input  logic               pd_wake_en,
   input  logic [N_IRQ-1:0]   irq_req,
   input  logic [N_IRQ-1:0]   irq_en,
   input  logic               stack_full,
   output logic               sys_clk_en,
   output logic               cpu_hold,
   output logic               resume_next,
   output logic               take_irq,
   output logic [IRQ_IDW-1:0] take_irq_id,
   output logic               warm_rst,
   output logic               chip_rst,
   output logic               to_flag,
   output logic               pdf_flag
);

   localparam int CNT_W  = $clog2(SETTLE_CYC);
   localparam int N_GRP  = 3;

   // Elaboration-time parameter checks
   generate
      if (PA_W < 1 || GRP_W < 1) begin : g_bad_width
         $error("pwk_halt_ctrl: port widths must be at least 1");
      end
      if (N_IRQ < 2) begin : g_bad_irq
         $error("pwk_halt_ctrl: N_IRQ must be at least 2");
      end
      if (HAS_EXT_IRQ != 0 && (EXT_IRQ_IDX < 0 || EXT_IRQ_IDX >= N_IRQ)) begin : g_bad_ext
         $error("pwk_halt_ctrl: EXT_IRQ_IDX out of range");
      end
      if (SETTLE_CYC < 2) begin : g_bad_settle
         $error("pwk_halt_ctrl: SETTLE_CYC must be at least 2");
      end
   endgenerate

   pwk_state_e          state_q;
   pwk_exit_e           exit_q;
   pwk_exit_e           exit_d;
   logic [IRQ_IDW-1:0]  id_q;
   logic                in_run, in_halt, in_settle;
   logic                halt_go;
   logic                a_hit;
   logic [N_GRP-1:0]    grp_hit;
   logic                port_hit;
   logic                irq_wake, irq_vec_ok;
   logic [IRQ_IDW-1:0]  irq_vec_id;
   logic                wake_any;
   logic                settle_last;
   logic                next_q, vec_q, warm_q, cold_q;
   logic                to_q, pdf_q;

   assign in_run    = (state_q == PWK_RUN);
   assign in_halt   = (state_q == PWK_HALT);
   assign in_settle = (state_q == PWK_SETTLE);
   assign halt_go   = in_run && halt_req && !ext_rst_req && !wdt_ovf;

   // Port A: one enable per pin
   pwk_edge_det #(.W(PA_W)) u_pa (
      .clk  (clk),
      .rst_n(rst_n),
      .pins (pa_in),
      .en   (pa_wake_en),
      .hit  (a_hit)
   );

   // Ports B, C, D: one enable per port
   logic [N_GRP*GRP_W-1:0] grp_pins;
   logic [N_GRP-1:0]       grp_en;
   assign grp_pins = {pd_in, pc_in, pb_in};
   assign grp_en   = {pd_wake_en, pc_wake_en, pb_wake_en};

   generate
      for (genvar g = 0; g < N_GRP; g++) begin : g_grp
         pwk_edge_det #(.W(GRP_W)) u_det (
            .clk  (clk),
            .rst_n(rst_n),
            .pins (grp_pins[g*GRP_W +: GRP_W]),
            .en   ({GRP_W{grp_en[g]}}),
            .hit  (grp_hit[g])
         );
      end
   endgenerate

   assign port_hit = a_hit || (|grp_hit);

   pwk_irq_gate #(
      .N      (N_IRQ),
      .HAS_EXT(HAS_EXT_IRQ),
      .EXT_IDX(EXT_IRQ_IDX),
      .IDW    (IRQ_IDW)
   ) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (halt_go),
      .req   (irq_req),
      .en    (irq_en),
      .wake  (irq_wake),
      .vec_ok(irq_vec_ok),
      .vec_id(irq_vec_id)
   );

   pwk_settle_timer #(.N(SETTLE_CYC), .CW(CNT_W)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (in_settle),
      .last (settle_last)
   );

   assign wake_any = in_halt && (ext_rst_req || wdt_ovf || irq_wake || port_hit);

   // Exit chosen by priority: external reset, watchdog, interrupt, port
   always_comb begin
      if (ext_rst_req)                            exit_d = PWK_EXIT_COLD;
      else if (wdt_ovf)                           exit_d = PWK_EXIT_WARM;
      else if (irq_wake && irq_vec_ok && !stack_full) exit_d = PWK_EXIT_VEC;
      else                                        exit_d = PWK_EXIT_NEXT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PWK_RUN;
         exit_q  <= PWK_EXIT_NEXT;
         id_q    <= '0;
         to_q    <= 1'b0;
         pdf_q   <= 1'b0;
         next_q  <= 1'b0;
         vec_q   <= 1'b0;
         warm_q  <= 1'b0;
         cold_q  <= 1'b0;
      end else begin
         next_q <= 1'b0;
         vec_q  <= 1'b0;
         warm_q <= 1'b0;
         cold_q <= 1'b0;
         unique case (state_q)
            PWK_RUN: begin
               if (ext_rst_req) begin
                  // Flags kept; the pin restarts the rest of the chip.
               end else if (wdt_ovf) begin
                  to_q   <= 1'b1;
                  cold_q <= 1'b1;
               end else if (halt_req) begin
                  state_q <= PWK_HALT;
                  pdf_q   <= 1'b1;
                  to_q    <= 1'b0;
               end else if (wdt_clr) begin
                  pdf_q <= 1'b0;
               end
            end
            PWK_HALT: begin
               if (wake_any) begin
                  state_q <= PWK_SETTLE;
                  exit_q  <= exit_d;
                  id_q    <= irq_vec_id;
                  if (ext_rst_req) begin
                     to_q  <= 1'b0;
                     pdf_q <= 1'b1;
                  end else if (wdt_ovf) begin
                     to_q  <= 1'b1;
                     pdf_q <= 1'b1;
                  end
               end
            end
            PWK_SETTLE: begin
               if (settle_last) begin
                  state_q <= PWK_RUN;
                  unique case (exit_q)
                     PWK_EXIT_NEXT: next_q <= 1'b1;
                     PWK_EXIT_VEC:  vec_q  <= 1'b1;
                     PWK_EXIT_WARM: warm_q <= 1'b1;
                     PWK_EXIT_COLD: cold_q <= 1'b1;
                     default:       next_q <= 1'b1;
                  endcase
               end
            end
            default: state_q <= PWK_RUN;
         endcase
      end
   end

   assign sys_clk_en  = !in_halt;
   assign cpu_hold    = !in_run;
   assign resume_next = next_q;
   assign take_irq    = vec_q;
   assign take_irq_id = id_q;
   assign warm_rst    = warm_q;
   assign chip_rst    = cold_q;
   assign to_flag     = to_q;
   assign pdf_flag    = pdf_q;

endmodule

// File: rtl/pwk_halt_ctrl_chk.sv
module pwk_halt_ctrl_chk #(
   parameter int SETTLE_CYC = 1024
) (
   input logic clk,
   input logic rst_n,
   input logic halt_req,
   input logic ext_rst_req,
   input logic wdt_ovf,
   input logic wdt_clr,
   input logic sys_clk_en,
   input logic cpu_hold,
   input logic resume_next,
   input logic take_irq,
   input logic warm_rst,
   input logic chip_rst,
   input logic to_flag,
   input logic pdf_flag
);

   // Length of the current settling run, counted at the ports.
   logic [31:0] settle_n;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      settle_n <= '0;
      else if (sys_clk_en && cpu_hold) settle_n <= settle_n + 32'd1;
      else                             settle_n <= '0;
   end

   p_halt_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_hold && halt_req && !ext_rst_req && !wdt_ovf)
      |=> (!sys_clk_en && cpu_hold && pdf_flag && !to_flag));

   p_exit_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({resume_next, take_irq, warm_rst, chip_rst}));

   p_settle_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (resume_next || take_irq || warm_rst) |-> (settle_n == SETTLE_CYC));

   p_strobe_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (resume_next || take_irq || warm_rst) |-> (!cpu_hold && $past(cpu_hold)));

   p_wdt_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_hold && wdt_ovf && !ext_rst_req)
      |=> (chip_rst && to_flag && (pdf_flag == $past(pdf_flag))));

   p_ext_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_hold && ext_rst_req)
      |=> ($stable(to_flag) && $stable(pdf_flag) && !chip_rst && cpu_hold == 1'b0));

   p_gate_implies_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_clk_en |-> cpu_hold);

   p_wake_keeps_pdf_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!sys_clk_en) && sys_clk_en) |-> pdf_flag);

   p_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_hold && wdt_clr && !halt_req && !ext_rst_req && !wdt_ovf) |=> !pdf_flag);

endmodule

bind pwk_halt_ctrl pwk_halt_ctrl_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .halt_req   (halt_req),
   .ext_rst_req(ext_rst_req),
   .wdt_ovf    (wdt_ovf),
   .wdt_clr    (wdt_clr),
   .sys_clk_en (sys_clk_en),
   .cpu_hold   (cpu_hold),
   .resume_next(resume_next),
   .take_irq   (take_irq),
   .warm_rst   (warm_rst),
   .chip_rst   (chip_rst),
   .to_flag    (to_flag),
   .pdf_flag   (pdf_flag)
);

// File: tb/sim_pwk_halt_ctrl.sv
`timescale 1ns/1ps
module sim_pwk_halt_ctrl;

   localparam int PA_W   = 8;
   localparam int GRP_W  = 8;
   localparam int NI     = 4;
   localparam int SETTLE = 1024;

   // Expected exit codes
   localparam int X_NONE = 0;
   localparam int X_NEXT = 1;
   localparam int X_VEC  = 2;
   localparam int X_WARM = 3;
   localparam int X_COLD = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic halt_req = 0, ext_rst_req = 0, wdt_ovf = 0, wdt_clr = 0;
   logic [PA_W-1:0]  pa_in = '1, pa_wake_en = '0;
   logic [GRP_W-1:0] pb_in = '1, pc_in = '1, pd_in = '1;
   logic pb_wake_en = 0, pc_wake_en = 0, pd_wake_en = 0;
   logic [NI-1:0] irq_req = '0, irq_en = '0;
   logic stack_full = 0;
   logic sys_clk_en, cpu_hold, resume_next, take_irq, warm_rst, chip_rst, to_flag, pdf_flag;
   logic [1:0] take_irq_id;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pwk_halt_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .ext_rst_req(ext_rst_req),
      .wdt_ovf(wdt_ovf), .wdt_clr(wdt_clr), .pa_in(pa_in), .pa_wake_en(pa_wake_en),
      .pb_in(pb_in), .pc_in(pc_in), .pd_in(pd_in), .pb_wake_en(pb_wake_en),
      .pc_wake_en(pc_wake_en), .pd_wake_en(pd_wake_en), .irq_req(irq_req),
      .irq_en(irq_en), .stack_full(stack_full), .sys_clk_en(sys_clk_en),
      .cpu_hold(cpu_hold), .resume_next(resume_next), .take_irq(take_irq),
      .take_irq_id(take_irq_id), .warm_rst(warm_rst), .chip_rst(chip_rst),
      .to_flag(to_flag), .pdf_flag(pdf_flag)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Waking interrupts: newly raised, not pending at entry, not index 0.
   function automatic logic [NI-1:0] waking(input logic [NI-1:0] pend, input logic [NI-1:0] nw);
      return nw & ~pend & 4'b1110;
   endfunction

   function automatic int exp_exit(input bit ext, input bit wdt, input logic [NI-1:0] wk,
                                   input logic [NI-1:0] en, input bit sf, input bit port);
      if (ext) return X_COLD;
      if (wdt) return X_WARM;
      if (wk != 0) return ((wk & en) != 0 && !sf) ? X_VEC : X_NEXT;
      if (port) return X_NEXT;
      return X_NONE;
   endfunction

   function automatic int exp_id(input logic [NI-1:0] c);
      for (int i = 0; i < NI; i++) if (c[i]) return i;
      return 0;
   endfunction

   function automatic int strobe_code();
      return {resume_next, take_irq, warm_rst, chip_rst};
   endfunction

   function automatic int code_vec(input int x);
      case (x)
         X_NEXT: return 8;
         X_VEC:  return 4;
         X_WARM: return 2;
         X_COLD: return 1;
         default: return 0;
      endcase
   endfunction

   task automatic enter_halt(input logic [NI-1:0] pend);
      @(negedge clk);
      irq_req  = pend;
      halt_req = 1;
      @(negedge clk);
      halt_req = 0;
      chk(!sys_clk_en && cpu_hold, "R2 halt gating", sys_clk_en, 0);
      chk(pdf_flag && !to_flag, "R2 flags at halt", {to_flag, pdf_flag}, 1);
      repeat (2) @(negedge clk);
      chk(!sys_clk_en, "R5 pending irq stays asleep", sys_clk_en, 0);
   endtask

   // Called one negedge after the wake stimulus was applied.
   task automatic finish_wake(input int xin, input int id, input bit disturb);
      int n = 0;
      int x = xin;
      ext_rst_req = 0;
      wdt_ovf     = 0;
      if (x == X_NONE) begin
         chk(!sys_clk_en, "R3 R4 R5 no wake expected", sys_clk_en, 0);
         ext_rst_req = 1;
         @(negedge clk);
         ext_rst_req = 0;
         x = X_COLD;
      end
      while (sys_clk_en && cpu_hold && n < 5000) begin
         if (disturb && n == 100) begin
            wdt_ovf = 1; halt_req = 1; ext_rst_req = 1;
         end else begin
            wdt_ovf = 0; halt_req = 0; ext_rst_req = 0;
         end
         n++;
         @(negedge clk);
      end
      wdt_ovf = 0; halt_req = 0; ext_rst_req = 0;
      chk(n == SETTLE, disturb ? "R14 settle length" : "R6 settle length", n, SETTLE);
      chk(strobe_code() == code_vec(x), "R6 R13 exit strobe", strobe_code(), code_vec(x));
      if (x == X_VEC) chk(take_irq_id == id, "R8 irq index", take_irq_id, id);
      chk(to_flag == (x == X_WARM), x == X_WARM ? "R10 to flag" : "R9 to flag", to_flag, x == X_WARM);
      chk(pdf_flag == 1'b1, "R9 R10 pdf flag", pdf_flag, 1);
      @(negedge clk);
      chk(strobe_code() == 0 && !cpu_hold, "R7 strobe one cycle", strobe_code(), 0);
      pa_in = '1; pb_in = '1; pc_in = '1; pd_in = '1;
      irq_req = '0;
      @(negedge clk);
   endtask

   // Full directed case: enables are set by the caller beforehand.
   task automatic run_case(input logic [NI-1:0] pend, input logic [NI-1:0] nw,
                           input logic [PA_W-1:0] pa_fall, input logic [2:0] grp_fall,
                           input bit ext, input bit wdt, input bit disturb);
      bit port;
      int x;
      logic [NI-1:0] wk;
      enter_halt(pend);
      irq_req     = pend | nw;
      pa_in       = ~pa_fall;
      pb_in       = grp_fall[0] ? 8'hF7 : 8'hFF;
      pc_in       = grp_fall[1] ? 8'h7F : 8'hFF;
      pd_in       = grp_fall[2] ? 8'hFE : 8'hFF;
      ext_rst_req = ext;
      wdt_ovf     = wdt;
      port = ((pa_fall & pa_wake_en) != 0) || (grp_fall[0] && pb_wake_en) ||
             (grp_fall[1] && pc_wake_en) || (grp_fall[2] && pd_wake_en);
      wk = waking(pend, nw);
      x  = exp_exit(ext, wdt, wk, irq_en, stack_full, port);
      @(negedge clk);
      finish_wake(x, exp_id(wk & irq_en), disturb);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(sys_clk_en && !cpu_hold, "R1 reset run state", {sys_clk_en, cpu_hold}, 2);
      chk(!to_flag && !pdf_flag, "R1 reset flags", {to_flag, pdf_flag}, 0);
      chk(strobe_code() == 0, "R1 reset strobes", strobe_code(), 0);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R3: enabled pin 4 falls
      pa_wake_en = 8'h10;
      run_case(4'b0000, 4'b0000, 8'h10, 3'b000, 0, 0, 0);
      // R3: pin 5 falls but only pin 4 enabled
      run_case(4'b0000, 4'b0000, 8'h20, 3'b000, 0, 0, 0);
      // R3: rising edges never wake
      pa_wake_en = 8'hFF;
      pa_in = 8'h00;
      @(negedge clk);
      enter_halt(4'b0000);
      pa_in = 8'hFF;
      @(negedge clk);
      finish_wake(X_NONE, 0, 0);
      pa_wake_en = 8'h00;

      // R12: watchdog clear while running
      chk(pdf_flag, "R12 pdf before clear", pdf_flag, 1);
      wdt_clr = 1;
      @(negedge clk);
      wdt_clr = 0;
      chk(!pdf_flag, "R12 pdf cleared", pdf_flag, 0);

      // R11: watchdog while running
      wdt_ovf = 1;
      @(negedge clk);
      wdt_ovf = 0;
      chk(chip_rst && to_flag && !pdf_flag, "R11 wdt in run", {chip_rst, to_flag, pdf_flag}, 6);
      @(negedge clk);
      ext_rst_req = 1;
      @(negedge clk);
      ext_rst_req = 0;
      chk(to_flag && !pdf_flag && strobe_code() == 0, "R11 ext in run",
          {to_flag, pdf_flag, strobe_code()}, 32'h20);

      // R4: group enables
      pb_wake_en = 0; pc_wake_en = 1;
      run_case(4'b0000, 4'b0000, 8'h00, 3'b001, 0, 0, 0);
      run_case(4'b0000, 4'b0000, 8'h00, 3'b010, 0, 0, 0);
      pc_wake_en = 0; pd_wake_en = 1;
      run_case(4'b0000, 4'b0000, 8'h00, 3'b100, 0, 0, 0);
      pd_wake_en = 0;

      // R5: pending at entry, and external-pin interrupt
      irq_en = 4'b1111;
      run_case(4'b0010, 4'b0010, 8'h00, 3'b000, 0, 0, 0);
      run_case(4'b0000, 4'b0001, 8'h00, 3'b000, 0, 0, 0);
      // R7: disabled interrupt, then stack full
      irq_en = 4'b0000;
      run_case(4'b0000, 4'b0100, 8'h00, 3'b000, 0, 0, 0);
      irq_en = 4'b0100; stack_full = 1;
      run_case(4'b0000, 4'b0100, 8'h00, 3'b000, 0, 0, 0);
      stack_full = 0;
      // R8: lowest enabled waking index
      irq_en = 4'b1110;
      run_case(4'b0000, 4'b1100, 8'h00, 3'b000, 0, 0, 0);
      irq_en = 4'b1000;
      run_case(4'b0000, 4'b1100, 8'h00, 3'b000, 0, 0, 0);
      // R13: coincident sources
      pa_wake_en = 8'hFF; irq_en = 4'b1111;
      run_case(4'b0000, 4'b0110, 8'h01, 3'b000, 1, 1, 0);
      run_case(4'b0000, 4'b0000, 8'h01, 3'b000, 0, 1, 0);
      run_case(4'b0000, 4'b0100, 8'h01, 3'b000, 0, 0, 0);
      // R9 R10 R14: reset wakes, disturbed settle
      run_case(4'b0000, 4'b0000, 8'h00, 3'b000, 1, 0, 1);
      run_case(4'b0000, 4'b0000, 8'h00, 3'b000, 0, 1, 1);
      run_case(4'b0000, 4'b0100, 8'h00, 3'b000, 0, 0, 1);

      // Constrained random cases
      for (int k = 0; k < 40; k++) begin
         logic [NI-1:0]   pend, nw;
         logic [PA_W-1:0] paf;
         logic [2:0]      gf;
         bit ext, wdt;
         pend       = NI'($urandom);
         nw         = ($urandom % 2 == 0) ? NI'($urandom) : '0;
         paf        = ($urandom % 2 == 0) ? PA_W'($urandom) : '0;
         gf         = 3'($urandom);
         ext        = ($urandom % 8 == 0);
         wdt        = ($urandom % 8 == 0);
         irq_en     = NI'($urandom);
         stack_full = ($urandom % 4 == 0);
         pa_wake_en = PA_W'($urandom);
         pb_wake_en = 1'($urandom);
         pc_wake_en = 1'($urandom);
         pd_wake_en = 1'($urandom);
         run_case(pend, nw, paf, gf, ext, wdt, ($urandom % 5 == 0));
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule